// File: doc/BRIEF.md
# Divide-by-three processor clock generator

This block derives a processor clock from a fast source clock. The processor clock runs at one third of the source frequency and is high for one source period in every three. The block also derives a peripheral clock at half the processor clock rate with a 50% duty cycle, and it passes the crystal clock through unchanged as an oscillator output. A static strap selects the clock that feeds the divider: either the crystal clock or an external frequency input.

A synchronizing clear input stops the divider and holds it at its starting phase. Several generators that are cleared from the same source and released together produce processor and peripheral clocks that are in phase. The clear passes through a two-register synchronizer in the source clock domain before it reaches the counter.

An active-low reset request is sampled at the moment the processor clock falls. The sampled value drives an active-high reset output, so that output only changes on falling edges of the processor clock. The analog oscillator and the input hysteresis are not modelled: both source clocks are plain digital inputs. All registers sit in the selected source clock domain and share a synchronous active-high reset.

Top module: `clkdiv3_gen`

## Requirements
- R1: `cpu_clk_o` repeats with a period of exactly 3 counted source edges, and is high for 1 of them. After a clear or a reset, the first counted source edge drives it high.
- R2: `per_clk_o` toggles on every rising edge of `cpu_clk_o` and at no other time apart from a clear or reset. This gives a period of 6 source cycles, high for 3 and low for 3. It goes high together with the first `cpu_clk_o` rise after a clear or reset.
- R3: While the synchronized clear is high, `cpu_clk_o` and `per_clk_o` stay low and the divider stays at its starting phase. Counting resumes from that phase once the clear is released.
- R4: `clr_i` passes through exactly two source-clock register stages. A value sampled on source edge k therefore acts on the divider at source edge k+2.
- R5: When `sel_ext_i` is 1 the divider is clocked by `ext_clk_i`, and when it is 0 by `xtal_clk_i`. Edges on the clock that is not selected have no effect on any registered output. The strap is treated as static and is only changed while `rst_i` is applied.
- R6: `osc_o` always equals `xtal_clk_i`, whatever the value of `sel_ext_i`.
- R7: `cpu_rst_o` loads the inverse of `res_n_i` on the source edge at which `cpu_clk_o` falls at the end of a count. It keeps its value on every other source edge.
- R8: While `rst_i` is high on a selected source edge, the block does the following: `cpu_clk_o` and `per_clk_o` go low, `cpu_rst_o` goes high, the divider returns to its starting phase and the clear synchronizer empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk_i | input | 1 | Crystal source clock |
| ext_clk_i | input | 1 | External frequency source clock |
| sel_ext_i | input | 1 | Static strap: 1 selects `ext_clk_i`, 0 selects `xtal_clk_i` |
| rst_i | input | 1 | Synchronous active-high reset, sampled on the selected source clock |
| clr_i | input | 1 | Active-high divider clear, synchronized internally |
| res_n_i | input | 1 | Active-low reset request |
| osc_o | output | 1 | Buffered crystal clock |
| cpu_clk_o | output | 1 | Processor clock: source divided by 3, high for 1 source period in 3 |
| per_clk_o | output | 1 | Peripheral clock: processor clock divided by 2, 50% duty |
| cpu_rst_o | output | 1 | Active-high reset, updated only when `cpu_clk_o` falls |

## Verification
On every selected source edge the assertions check the local shape of the waveforms. They check that the processor clock is high for a single edge and always low on the edge after it falls, and that the peripheral clock changes only when the processor clock rises. They also check that an active clear holds both clocks low on the following edge, that the synchronizer output is the clear input from two edges earlier, and that the reset output moves only at a processor clock fall, where it takes the inverted request. Some behaviour can only be shown by the bench scenarios, which compare against a count-based model. This covers the exact phase after a clear is released at different offsets, the switch of the divider between the two sources, the freezing of the outputs when the selected clock stops, and the oscillator output following the crystal while the external source is in use.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;

  // Width of a counter that holds values 0 .. n-1 (never narrower than 1 bit)
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Outputs of the phase divider, grouped for the top level
  typedef struct packed {
    logic cpu;
    logic per;
    logic fall;
  } phase_out_t;

endpackage

// File: rtl/clkdiv3_src_sel.sv
// Static source-clock selection and oscillator pass-through.
module clkdiv3_src_sel (
  input  logic xtal_clk_i,
  input  logic ext_clk_i,
  input  logic sel_ext_i,
  output logic src_clk_o,
  output logic osc_o
);

  // The strap is static: it is only changed while both clocks are quiet
  assign src_clk_o = sel_ext_i ? ext_clk_i : xtal_clk_i;
  assign osc_o     = xtal_clk_i;

endmodule

// File: rtl/clkdiv3_sync.sv
// Multi-stage synchronizer for the clear input.
module clkdiv3_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkdiv3_phase.sv
// Divider counter with registered processor and peripheral clocks.
module clkdiv3_phase
  import clkdiv3_pkg::*;
#(
  parameter int DIV      = 3,
  parameter int HIGH_CYC = 1
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       clr_i,
  output phase_out_t out_o
);

  localparam int            CW   = cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HI   = CW'(HIGH_CYC);

  logic [CW-1:0] cnt_q;
  logic          cpu_q;
  logic          per_q;
  logic          hold;

  assign hold = rst_i | clr_i;

  // Counter position 0 is the starting phase; the first counted edge drives cpu high
  always_ff @(posedge clk_i) begin
    if (hold) begin
      cnt_q <= '0;
      cpu_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      cpu_q <= (cnt_q < HI);
      if (cnt_q == '0) per_q <= ~per_q;
    end
  end

  // Strobe: this edge is the one at which cpu falls at the end of a count
  assign out_o.fall = ~hold & (cnt_q == HI);
  assign out_o.cpu  = cpu_q;
  assign out_o.per  = per_q;

endmodule

// File: rtl/clkdiv3_rstcap.sv
// Captures the reset request at the processor clock's falling edge.
module clkdiv3_rstcap (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fall_i,
  input  logic res_n_i,
  output logic rst_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i)       rst_o <= 1'b1;
    else if (fall_i) rst_o <= ~res_n_i;
  end

endmodule

// File: rtl/clkdiv3_gen.sv
module clkdiv3_gen
  import clkdiv3_pkg::*;
#(
  parameter int DIV         = 3,
  parameter int HIGH_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic xtal_clk_i,
  input  logic ext_clk_i,
  input  logic sel_ext_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic res_n_i,
  output logic osc_o,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic cpu_rst_o
);

  logic       src_clk;
  logic       clr_sync;
  phase_out_t ph;

  clkdiv3_src_sel u_src (
    .xtal_clk_i (xtal_clk_i),
    .ext_clk_i  (ext_clk_i),
    .sel_ext_i  (sel_ext_i),
    .src_clk_o  (src_clk),
    .osc_o      (osc_o)
  );

  clkdiv3_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (src_clk),
    .rst_i (rst_i),
    .d_i   (clr_i),
    .q_o   (clr_sync)
  );

  clkdiv3_phase #(.DIV(DIV), .HIGH_CYC(HIGH_CYC)) u_phase (
    .clk_i (src_clk),
    .rst_i (rst_i),
    .clr_i (clr_sync),
    .out_o (ph)
  );

  clkdiv3_rstcap u_rst (
    .clk_i   (src_clk),
    .rst_i   (rst_i),
    .fall_i  (ph.fall),
    .res_n_i (res_n_i),
    .rst_o   (cpu_rst_o)
  );

  assign cpu_clk_o = ph.cpu;
  assign per_clk_o = ph.per;

endmodule

// File: rtl/clkdiv3_gen_chk.sv
module clkdiv3_gen_chk (
  input logic src_clk,
  input logic rst_i,
  input logic clr_i,
  input logic clr_sync,
  input logic res_n_i,
  input logic cpu_clk_o,
  input logic per_clk_o,
  input logic cpu_rst_o
);

  AST_CPU_HIGH_ONE: assert property (@(posedge src_clk) disable iff (rst_i)
    $rose(cpu_clk_o) |=> !cpu_clk_o); // R1

  AST_CPU_LOW_AFTER_FALL: assert property (@(posedge src_clk) disable iff (rst_i)
    $fell(cpu_clk_o) |=> !cpu_clk_o); // R1

  AST_PER_ON_CPU_RISE: assert property (@(posedge src_clk) disable iff (rst_i)
    (!$stable(per_clk_o) && !$past(clr_sync) && !$past(rst_i)) |-> $rose(cpu_clk_o)); // R2

  AST_CLEAR_HOLDS: assert property (@(posedge src_clk) disable iff (rst_i)
    clr_sync |=> (!cpu_clk_o && !per_clk_o)); // R3

  AST_SYNC_DEPTH: assert property (@(posedge src_clk) disable iff (rst_i)
    (!$past(rst_i) && !$past(rst_i, 2)) |-> (clr_sync == $past(clr_i, 2))); // R4

  AST_RST_ONLY_AT_FALL: assert property (@(posedge src_clk) disable iff (rst_i)
    (!$stable(cpu_rst_o) && !$past(rst_i)) |-> $fell(cpu_clk_o)); // R7

  AST_RST_CAPTURE: assert property (@(posedge src_clk) disable iff (rst_i)
    ($fell(cpu_clk_o) && !$past(clr_sync) && !$past(rst_i)) |-> (cpu_rst_o == !$past(res_n_i))); // R7

endmodule

bind clkdiv3_gen clkdiv3_gen_chk u_chk (
  .src_clk   (src_clk),
  .rst_i     (rst_i),
  .clr_i     (clr_i),
  .clr_sync  (clr_sync),
  .res_n_i   (res_n_i),
  .cpu_clk_o (cpu_clk_o),
  .per_clk_o (per_clk_o),
  .cpu_rst_o (cpu_rst_o)
);

// File: tb/clkdiv3_gen_tb.sv
`timescale 1ns/1ps
module clkdiv3_gen_tb;

  logic clk = 1'b0;
  logic xen = 1'b1, een = 1'b0;
  logic sel = 1'b0, rst = 1'b1, clr = 1'b0, res_n = 1'b0;
  logic xtal, ext;
  logic osc, cpu, per, crst;

  int   n_vec = 0, n_bad = 0;
  string tag = "R8";

  // model state
  int   n = 0;
  bit   m_rst = 1'b1;
  bit   clrq[$] = '{1'b0, 1'b0};

  always #2 clk = ~clk;  // 250 MHz
  assign xtal = clk & xen;
  assign ext  = clk & een;

  clkdiv3_gen u_dut (
    .xtal_clk_i (xtal), .ext_clk_i (ext), .sel_ext_i (sel),
    .rst_i (rst), .clr_i (clr), .res_n_i (res_n),
    .osc_o (osc), .cpu_clk_o (cpu), .per_clk_o (per), .cpu_rst_o (crst)
  );

  function automatic bit exp_cpu(int k);
    return (k % 3) == 1;
  endfunction

  function automatic bit exp_per(int k);
    return (k >= 1) && ((((k - 1) / 3) % 2) == 0);
  endfunction

  task automatic chk(string req, string what, bit act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s %s act=%0b exp=%0b t=%0t", tag, req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (sel ? een : xen) begin
      if (rst) begin
        n = 0; m_rst = 1'b1; clrq = '{1'b0, 1'b0};
      end else begin
        bit eff;
        clrq.push_back(clr);
        eff = clrq.pop_front();
        if (eff) n = 0;
        else begin
          n++;
          if ((n % 3) == 2) m_rst = !res_n;
        end
      end
    end
    #1;
    chk("R1", "cpu_clk", cpu, exp_cpu(n));
    chk("R2", "per_clk", per, exp_per(n));
    chk("R7", "cpu_rst", crst, m_rst);
    chk("R6", "osc", osc, xen);
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    cyc(4);                       // R8: reset state held
    rst = 1'b0; tag = "R1";
    cyc(20);
    tag = "R7";
    res_n = 1'b1; cyc(12);
    res_n = 1'b0; cyc(1); res_n = 1'b1; cyc(7);
    res_n = 1'b0; cyc(2); res_n = 1'b1; cyc(9);
    tag = "R3";
    clr = 1'b1; cyc(6); clr = 1'b0; cyc(14);
    for (int k = 0; k < 3; k++) begin
      cyc(k + 1); clr = 1'b1; cyc(2); clr = 1'b0; cyc(11);
    end
    tag = "R4";
    clr = 1'b1; cyc(3); clr = 1'b0; cyc(1); clr = 1'b1; cyc(2); clr = 1'b0; cyc(12);
    tag = "R5";
    xen = 1'b0; cyc(6); xen = 1'b1; cyc(10);   // selected xtal stops: outputs freeze
    xen = 1'b0; een = 1'b0; rst = 1'b1; sel = 1'b1; cyc(2);
    een = 1'b1; cyc(3); rst = 1'b0; cyc(25);
    tag = "R6";
    xen = 1'b1; res_n = 1'b0; cyc(20);
    een = 1'b0; cyc(8);                        // selected ext stops, xtal runs
    een = 1'b1; xen = 1'b0; res_n = 1'b1; cyc(15);
    tag = "R8";
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(10);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog R1 act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule